// File: doc/BRIEF.md
# Stereo Audio Frame Serializer

This block turns parallel stereo sample pairs into a one-wire serial data stream for a 64-period frame. Each frame holds two 32-period halves, left first, then right. Each half carries one 24-bit sample, most significant bit first, and the remaining periods of the half are driven low. The block does not generate the bit clock or the frame clock. It runs on the system clock and reacts to single-cycle strobes that mark each bit-clock falling edge and the falling edge that opens a frame. Data therefore changes where a receiver will not sample it, and is stable at the following rising edge.

Two alignments are supported. In the justified alignment, the sample's top bit occupies the first bit period after the frame edge. In the delayed alignment, which is I2S, every data bit arrives one bit period later and the first period of each half is low. The alignment is read from a strap level on the first system clock after reset is released. It is then held until the next reset.

An upstream producer hands over sample pairs through a valid/ready handshake into a one-pair holding register. At every frame start the held pair becomes the pair being sent. If nothing is held at that moment, the previous pair is sent again and an underrun flag marks the frame.

Top module: `audio_frame_serializer`

## Requirements
- R1: The strap is sampled on the first clock after reset release: level 1 selects the delayed (I2S) alignment and level 0 selects the justified alignment; later changes of the strap have no effect on the output until the next reset.
- R2: In justified alignment, bit period k (k = 0..23) after a half's start carries sample bit 23-k.
- R3: In delayed alignment, bit period 0 of each half is low and bit period k+1 (k = 0..23) carries sample bit 23-k.
- R4: Periods 0..31 of a frame carry the left sample and periods 32..63 carry the right sample.
- R5: Every period of a half that carries no sample bit is driven low.
- R6: The serial output changes only on a clock where the bit-fall strobe is high.
- R7: inReady is high while the holding register is empty. A pair is taken when inValid and inReady are both high, inReady then stays low until the next frame start, and the held pair is the one sent from that frame start.
- R8: If no pair is held at a frame start, the previous pair is repeated and underrun is high for that frame; underrun goes low at the next frame start that finds a held pair.
- R9: After reset, sdOut and underrun are low and inReady is high. Bit strobes arriving before the first frame strobe leave sdOut low, and before any pair is accepted the pair being sent is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strapLevel | input | 1 | Alignment strap, sampled once after reset |
| bitFallStb | input | 1 | One-cycle strobe for each bit-clock falling edge |
| frameStb | input | 1 | Qualifies bitFallStb as the edge that opens a frame |
| inValid | input | 1 | Producer has a sample pair |
| inLeft | input | 24 | Left sample |
| inRight | input | 24 | Right sample |
| inReady | output | 1 | Holding register empty |
| sdOut | output | 1 | Serial data line |
| underrun | output | 1 | The current frame repeats the previous pair |

## Verification
A wrong slot counter or a wrong alignment flag shows up in sdOut at once. Every bit period of a frame is compared, so an off-by-one delay or a swapped half fails within the first frame after the fault. A wrong holding-register state appears at the next frame start, either as a stale or fresh pair in the data or as a wrong underrun level. A strap sampled at the wrong time shows up across a whole frame once the strap pin is toggled after reset.

// File: rtl/afs_pkg.sv
package afs_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureIn;  // take the offered pair into the holding register
    logic promote;    // move the held pair to the pair being sent
    logic drive;      // update the serial output for a new bit period
    logic fmtI2s;     // 1: one-period delayed alignment
  } ctlStrobes_t;

endpackage

// File: rtl/afs_control.sv
module afs_control
  import afs_pkg::*;
#(
  parameter int SLOT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strapLevel,
  input  logic                 bitFallStb,
  input  logic                 frameStb,
  input  logic                 inValid,
  output logic                 inReady,
  output logic                 underrun,
  output logic [$clog2(2*SLOT_W)-1:0] slotNext,
  output ctlStrobes_t          ctl
);

  localparam int FRAME_W = 2 * SLOT_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic             strapDone;
  logic             fmtI2s;
  logic             running;
  logic             holdFull;
  logic [CNT_W-1:0] slotIdx;
  logic             frameStart;
  logic             accept;

  assign frameStart = bitFallStb && frameStb && strapDone;
  assign accept     = inValid && !holdFull;
  assign inReady    = !holdFull;
  assign slotNext   = frameStb ? '0 : slotIdx + 1'b1;

  always_comb begin
    ctl.captureIn = accept;
    ctl.promote   = frameStart && holdFull;
    ctl.drive     = bitFallStb && strapDone && (running || frameStb);
    ctl.fmtI2s    = fmtI2s;
  end

  // Strap capture: once, on the first clock after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strapDone <= 1'b0;
      fmtI2s    <= 1'b0;
    end else if (!strapDone) begin
      strapDone <= 1'b1;
      fmtI2s    <= strapLevel;
    end
  end

  // Bit period counter within the frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      slotIdx <= '0;
    end else if (ctl.drive) begin
      running <= 1'b1;
      slotIdx <= slotNext;
    end
  end

  // Holding register occupancy and underrun flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdFull <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (ctl.promote)   holdFull <= 1'b0;
      else if (accept)   holdFull <= 1'b1;
      if (frameStart)    underrun <= !holdFull;
    end
  end

  AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    strapDone |=> $stable(fmtI2s)); // R1

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !inReady); // R7

  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && !holdFull) |=> underrun); // R8

  AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> (slotIdx == '0)); // R4

endmodule

// File: rtl/afs_datapath.sv
module afs_datapath
  import afs_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctlStrobes_t                 ctl,
  input  logic [$clog2(2*SLOT_W)-1:0] slotNext,
  input  logic [SAMPLE_W-1:0]         inLeft,
  input  logic [SAMPLE_W-1:0]         inRight,
  output logic                        sdOut
);

  localparam int CNT_W  = $clog2(2 * SLOT_W);
  localparam int SLOT_IW = $clog2(SLOT_W);

  logic [SAMPLE_W-1:0] holdL, holdR, actL, actR;
  logic [SAMPLE_W-1:0] srcL, srcR, word, shifted;
  logic [SLOT_IW-1:0]  pos, off;
  logic                inRange;
  logic                nextBit;

  // Pair used for the upcoming period: the fresh one at a promoting frame start
  assign srcL = ctl.promote ? holdL : actL;
  assign srcR = ctl.promote ? holdR : actR;

  always_comb begin
    pos     = slotNext[SLOT_IW-1:0];
    word    = slotNext[CNT_W-1] ? srcR : srcL;
    off     = pos - SLOT_IW'(ctl.fmtI2s);
    inRange = (ctl.fmtI2s ? (pos != '0) : 1'b1) && (off < SLOT_IW'(SAMPLE_W));
    shifted = word << off;
    nextBit = inRange && shifted[SAMPLE_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdL <= '0;
      holdR <= '0;
      actL  <= '0;
      actR  <= '0;
      sdOut <= 1'b0;
    end else begin
      if (ctl.captureIn) begin
        holdL <= inLeft;
        holdR <= inRight;
      end
      if (ctl.promote) begin
        actL <= holdL;
        actR <= holdR;
      end
      if (ctl.drive) sdOut <= nextBit;
    end
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.drive |=> $stable(sdOut)); // R6

  AST_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.drive && (slotNext[SLOT_IW-1:0] > SLOT_IW'(SAMPLE_W))) |=> !sdOut); // R5

endmodule

// File: rtl/audio_frame_serializer.sv
module audio_frame_serializer
  import afs_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strapLevel,
  input  logic                bitFallStb,
  input  logic                frameStb,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                inReady,
  output logic                sdOut,
  output logic                underrun
);

  localparam int CNT_W = $clog2(2 * SLOT_W);

  ctlStrobes_t      ctl;
  logic [CNT_W-1:0] slotNext;

  afs_control #(.SLOT_W(SLOT_W)) uCtl (
    .clk        (clk),
    .rst_n      (rst_n),
    .strapLevel (strapLevel),
    .bitFallStb (bitFallStb),
    .frameStb   (frameStb),
    .inValid    (inValid),
    .inReady    (inReady),
    .underrun   (underrun),
    .slotNext   (slotNext),
    .ctl        (ctl)
  );

  afs_datapath #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .slotNext (slotNext),
    .inLeft   (inLeft),
    .inRight  (inRight),
    .sdOut    (sdOut)
  );

endmodule

// File: tb/audio_frame_serializer_test.sv
module audio_frame_serializer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strapLevel = 1'b0;
  logic        bitFallStb = 1'b0;
  logic        frameStb = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] inLeft = '0;
  logic [23:0] inRight = '0;
  logic        inReady, sdOut, underrun;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit          fmtExp;
  bit          pend;
  logic [23:0] expL, expR, pendL, pendR;

  always #2 clk = ~clk;  // 250 MHz

  audio_frame_serializer uut (
    .clk(clk), .rst_n(rst_n), .strapLevel(strapLevel),
    .bitFallStb(bitFallStb), .frameStb(frameStb),
    .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .inReady(inReady), .sdOut(sdOut), .underrun(underrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit expBit(bit i2s, int s, logic [23:0] l, logic [23:0] r);
    int pos = s % 32;
    int k = pos - (i2s ? 1 : 0);
    logic [23:0] w = (s >= 32) ? r : l;
    if (k < 0 || k >= 24) return 1'b0;
    return w[23 - k];
  endfunction

  task automatic doReset(input bit strap);
    rst_n = 1'b0;
    strapLevel = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fmtExp = strap;
    pend = 0;
    expL = '0;
    expR = '0;
    @(negedge clk);
    @(negedge clk);
    strapLevel = ~strap;  // must be ignored from now on (R1)
    chk("R9 sdOut after reset", sdOut, 0);
    chk("R9 inReady after reset", inReady, 1);
    chk("R9 underrun after reset", underrun, 0);
    // bit strobes without a frame strobe: output stays low
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) bitFallStb = 1'b1;
      @(negedge clk) bitFallStb = 1'b0;
      chk("R9 idle before first frame", sdOut, 0);
    end
  endtask

  task automatic runFrame(input bit offer, input logic [23:0] l, input logic [23:0] r);
    for (int s = 0; s < 64; s++) begin
      @(negedge clk);
      bitFallStb = 1'b1;
      frameStb = (s == 0);
      @(negedge clk);
      bitFallStb = 1'b0;
      frameStb = 1'b0;
      if (s == 0) begin
        chk("R8 underrun at frame start", underrun, pend ? 0 : 1);
        if (pend) begin
          expL = pendL;
          expR = pendR;
        end
        pend = 0;
        chk("R7 ready after frame start", inReady, 1);
        chk("R1 first period selects alignment", sdOut, fmtExp ? 0 : expL[23]);
      end
      if (expBit(fmtExp, s, 24'hFFFFFF, 24'hFFFFFF) == 1'b0)
        chk("R5 unused period low", sdOut, 0);
      else if (s >= 32)
        chk(fmtExp ? "R4 R3 right data bit" : "R4 R2 right data bit",
            sdOut, expBit(fmtExp, s, expL, expR));
      else
        chk(fmtExp ? "R3 left data bit" : "R2 left data bit",
            sdOut, expBit(fmtExp, s, expL, expR));
      @(negedge clk);
      chk("R6 output held between strobes", sdOut, expBit(fmtExp, s, expL, expR));
      if (offer && s == 8) begin
        chk("R7 ready before offer", inReady, 1);
        inValid = 1'b1;
        inLeft = l;
        inRight = r;
      end
      @(negedge clk);
      if (offer && s == 8) begin
        inValid = 1'b0;
        pend = 1;
        pendL = l;
        pendR = r;
        chk("R7 ready low while holding", inReady, 0);
      end
    end
  endtask

  task automatic phase(input bit strap);
    doReset(strap);
    // first frame has no pair held: zeros and underrun (R8, R9); offer during it
    runFrame(1'b1, 24'hFFFFFF, 24'h000001);
    runFrame(1'b1, 24'h800001, 24'hA5A5A5);
    runFrame(1'b1, 24'($urandom), 24'($urandom));
    runFrame(1'b0, 24'h0, 24'h0);                  // nothing offered for next frame
    runFrame(1'b1, 24'($urandom), 24'($urandom));  // repeated pair, underrun high
    runFrame(1'b1, 24'($urandom), 24'($urandom));
    runFrame(1'b0, 24'h0, 24'h0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    phase(1'b0);
    phase(1'b1);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule